// File: doc/BRIEF.md
# Shared Second-Level Translation Buffer with Page Walker

This block is the second translation level behind two first-level buffers, one on the instruction path and one on the data path. When either first-level buffer misses, it raises a request carrying a 20-bit virtual page number. It holds that request until it gets a done pulse back. The block arbitrates between the two sides and looks the page up in a 64-entry, 2-way set-associative array (32 sets). On a hit it returns the cached physical page number.

On a miss it fetches a page table entry through a single memory read port. The entry address is a programmable table base plus the page number times four. The block then installs the translation and answers the requester. An entry whose present bit is clear is answered as a translation fault and is not cached. Pages are 4 KB, so the low 12 address bits never reach this block.

The controller is a five-state machine:
- IDLE: accepts the arbiter's grant.
- LOOKUP: compares tags.
- WALK_RD: issues the memory read strobe.
- WALK_WAIT: waits for the read data and installs a good entry.
- RESPOND: pulses done to the granted side.

The transitions are:
- IDLE→LOOKUP on any request.
- LOOKUP→RESPOND on a hit, and LOOKUP→WALK_RD on a miss.
- WALK_RD→WALK_WAIT always.
- WALK_WAIT stays put until read data returns, then WALK_WAIT→RESPOND.
- RESPOND→IDLE always.

Top module: `l2_xlate_buf`

## Requirements
- R1: The set index is VPN bits 4:0 and the tag is VPN bits 19:5 with a valid bit; two pages that differ in either field hold separate entries, and a page is found only by its own tag in its own set.
- R2: A hit raises done on the granted side in the second cycle after the accepting edge, with the stored physical page number, no fault and no memory read.
- R3: A miss issues exactly one single-cycle read strobe at address table_base + VPN*4; done follows in the cycle after read data is accepted.
- R4: A returned entry with bit 0 set yields physical page number = data bits 31:12 without fault and is installed, so the next lookup of that page hits.
- R5: A returned entry with bit 0 clear yields done with the fault flag and is not installed, so a repeated lookup walks again.
- R6: An install fills way 0 if invalid, else way 1 if invalid; if both ways are valid it replaces the way named by a per-set toggle bit (0 after reset), which then inverts.
- R7: When both sides request in the same cycle the grant alternates; the first such tie after reset goes to the instruction side, and any grant moves priority to the other side.
- R8: Requests are accepted only in IDLE; a side that loses arbitration keeps its request and is served after the current one completes, with its own correct result.
- R9: flush_all clears every valid bit in one cycle; if it coincides with an install, the flush wins and the entry is not kept.
- R10: done is a one-cycle pulse, at most one side's done is high at a time, and a fault flag is high only with its done.
- R11: After reset no done or read strobe is active and every entry is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_all | input | 1 | Invalidate every entry |
| i_req | input | 1 | Instruction-side request, held until i_done |
| i_vpn | input | 20 | Instruction-side virtual page number |
| i_done | output | 1 | Instruction-side completion pulse |
| i_fault | output | 1 | Instruction-side translation fault, with i_done |
| i_ppn | output | 20 | Instruction-side physical page number, valid with i_done |
| d_req | input | 1 | Data-side request, held until d_done |
| d_vpn | input | 20 | Data-side virtual page number |
| d_done | output | 1 | Data-side completion pulse |
| d_fault | output | 1 | Data-side translation fault, with d_done |
| d_ppn | output | 20 | Data-side physical page number, valid with d_done |
| table_base | input | 32 | Byte address of the page table |
| mem_rd_req | output | 1 | One-cycle read strobe |
| mem_rd_addr | output | 32 | Read address of the page table entry |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | 32 | Returned page table entry |

## Verification
The checker watches the following on every cycle:
- The done pulse is exclusive, lasts one cycle, and its fault flag is consistent with it (R10).
- The read strobe lasts exactly one cycle (R3).
- Every returned entry turns into the next-cycle answer, a fault for a clear present bit (R5) and the entry's page number otherwise (R4).

Some behaviours need a reference cache model running through the bench's scenarios:
- Hit/miss decisions, including victim choice under the toggle bit (R1, R6).
- Hit and miss latency (R2, R3).
- Alternating arbitration and the stalled requester being served (R7, R8).
- Effects of a flush, including one that lands on the install cycle (R9).

// File: rtl/xl_pkg.sv
package xl_pkg;

    localparam int VPN_W_DEF    = 20;
    localparam int PPN_W_DEF    = 20;
    localparam int SET_BITS_DEF = 5;
    localparam int ADDR_W_DEF   = 32;
    localparam int DATA_W_DEF   = 32;
    localparam int WAYS         = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WALK_RD,
        ST_WALK_WAIT,
        ST_RESPOND
    } xl_state_e;

    typedef enum logic {
        SIDE_INSTR = 1'b0,
        SIDE_DATA  = 1'b1
    } xl_side_e;

endpackage

// File: rtl/xl_arb.sv
module xl_arb #(
    parameter int VPN_W = xl_pkg::VPN_W_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 i_req,
    input  logic [VPN_W-1:0]     i_vpn,
    input  logic                 d_req,
    input  logic [VPN_W-1:0]     d_vpn,
    input  logic                 accept,
    output logic                 gnt_valid,
    output xl_pkg::xl_side_e     gnt_side,
    output logic [VPN_W-1:0]     gnt_vpn
);
    import xl_pkg::*;

    // priority pointer: 1 = instruction side wins a tie
    logic instr_first_q;

    always_comb begin
        gnt_valid = i_req | d_req;
        if (i_req && (!d_req || instr_first_q)) begin
            gnt_side = SIDE_INSTR;
            gnt_vpn  = i_vpn;
        end else begin
            gnt_side = SIDE_DATA;
            gnt_vpn  = d_vpn;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            instr_first_q <= 1'b1;
        end else if (accept) begin
            instr_first_q <= (gnt_side == SIDE_DATA);
        end
    end

endmodule

// File: rtl/xl_array.sv
module xl_array #(
    parameter int VPN_W    = xl_pkg::VPN_W_DEF,
    parameter int PPN_W    = xl_pkg::PPN_W_DEF,
    parameter int SET_BITS = xl_pkg::SET_BITS_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             wr_en,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PPN_W-1:0] wr_ppn
);
    import xl_pkg::*;

    localparam int SETS  = 1 << SET_BITS;
    localparam int TAG_W = VPN_W - SET_BITS;

    logic [SET_BITS-1:0] lk_idx;
    logic [TAG_W-1:0]    lk_tag;
    logic [SET_BITS-1:0] wr_idx;
    logic [TAG_W-1:0]    wr_tag;

    assign lk_idx = lk_vpn[SET_BITS-1:0];
    assign lk_tag = lk_vpn[VPN_W-1:SET_BITS];
    assign wr_idx = wr_vpn[SET_BITS-1:0];
    assign wr_tag = wr_vpn[VPN_W-1:SET_BITS];

    logic [WAYS-1:0]  way_hit;
    logic [WAYS-1:0]  way_full;   // valid bit of each way at the install set
    logic [PPN_W-1:0] way_ppn [WAYS];

    logic [SETS-1:0]  tog_q;
    logic             victim;
    logic             set_full;

    // victim: first invalid way, else the per-set toggle
    always_comb begin
        set_full = &way_full;
        if (!way_full[0]) begin
            victim = 1'b0;
        end else if (!way_full[1]) begin
            victim = 1'b1;
        end else begin
            victim = tog_q[wr_idx];
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [SETS-1:0]  vld_q;
        logic [TAG_W-1:0] tag_q [SETS];
        logic [PPN_W-1:0] ppn_q [SETS];
        logic             sel;

        assign sel         = wr_en && (victim == 1'(w));
        assign way_hit[w]  = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
        assign way_ppn[w]  = ppn_q[lk_idx];
        assign way_full[w] = vld_q[wr_idx];

        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                vld_q <= '0;
            end else if (sel) begin
                vld_q[wr_idx] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                tag_q[wr_idx] <= wr_tag;
                ppn_q[wr_idx] <= wr_ppn;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog_q <= '0;
        end else if (wr_en && set_full && !flush) begin
            tog_q[wr_idx] <= ~tog_q[wr_idx];
        end
    end

    assign lk_hit = |way_hit;
    assign lk_ppn = way_hit[1] ? way_ppn[1] : way_ppn[0];

endmodule

// File: rtl/xl_ctrl.sv
module xl_ctrl #(
    parameter int VPN_W  = xl_pkg::VPN_W_DEF,
    parameter int PPN_W  = xl_pkg::PPN_W_DEF,
    parameter int ADDR_W = xl_pkg::ADDR_W_DEF,
    parameter int DATA_W = xl_pkg::DATA_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               gnt_valid,
    input  xl_pkg::xl_side_e   gnt_side,
    input  logic [VPN_W-1:0]   gnt_vpn,
    output logic               accept,
    output logic [VPN_W-1:0]   cur_vpn,
    input  logic               lk_hit,
    input  logic [PPN_W-1:0]   lk_ppn,
    output logic               wr_en,
    output logic [PPN_W-1:0]   wr_ppn,
    input  logic [ADDR_W-1:0]  table_base,
    output logic               mem_rd_req,
    output logic [ADDR_W-1:0]  mem_rd_addr,
    input  logic               mem_rd_valid,
    input  logic [DATA_W-1:0]  mem_rd_data,
    output logic               i_done,
    output logic               d_done,
    output logic [PPN_W-1:0]   rsp_ppn,
    output logic               rsp_fault
);
    import xl_pkg::*;

    localparam int PTE_STRIDE_SH = 2;

    xl_state_e    state_q, state_d;
    xl_side_e     side_q;
    logic [VPN_W-1:0] vpn_q;
    logic [PPN_W-1:0] ppn_q;
    logic         fault_q;
    logic         pte_present;
    logic         unused_pte_bits;

    assign pte_present     = mem_rd_data[0];
    assign wr_ppn          = mem_rd_data[DATA_W-1 -: PPN_W];
    assign unused_pte_bits = ^mem_rd_data[DATA_W-PPN_W-1:1];
    assign cur_vpn         = vpn_q;
    assign mem_rd_addr     = table_base + (ADDR_W'(vpn_q) << PTE_STRIDE_SH);
    assign rsp_ppn         = ppn_q;
    assign rsp_fault       = fault_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (gnt_valid) state_d = ST_LOOKUP;
            ST_LOOKUP:    state_d = lk_hit ? ST_RESPOND : ST_WALK_RD;
            ST_WALK_RD:   state_d = ST_WALK_WAIT;
            ST_WALK_WAIT: if (mem_rd_valid) state_d = ST_RESPOND;
            ST_RESPOND:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept     = 1'b0;
        mem_rd_req = 1'b0;
        wr_en      = 1'b0;
        i_done     = 1'b0;
        d_done     = 1'b0;
        unique case (state_q)
            ST_IDLE:      accept = gnt_valid;
            ST_LOOKUP:    ;
            ST_WALK_RD:   mem_rd_req = 1'b1;
            ST_WALK_WAIT: wr_en = mem_rd_valid && pte_present;
            ST_RESPOND: begin
                i_done = (side_q == SIDE_INSTR);
                d_done = (side_q == SIDE_DATA);
            end
            default:      ;
        endcase
    end

    // request and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            side_q  <= SIDE_INSTR;
            vpn_q   <= '0;
            ppn_q   <= '0;
            fault_q <= 1'b0;
        end else begin
            if (state_q == ST_IDLE && gnt_valid) begin
                side_q <= gnt_side;
                vpn_q  <= gnt_vpn;
            end
            if (state_q == ST_LOOKUP && lk_hit) begin
                ppn_q   <= lk_ppn;
                fault_q <= 1'b0;
            end
            if (state_q == ST_WALK_WAIT && mem_rd_valid) begin
                ppn_q   <= wr_ppn;
                fault_q <= !pte_present;
            end
        end
    end

endmodule

// File: rtl/l2_xlate_buf.sv
module l2_xlate_buf #(
    parameter int VPN_W    = xl_pkg::VPN_W_DEF,
    parameter int PPN_W    = xl_pkg::PPN_W_DEF,
    parameter int SET_BITS = xl_pkg::SET_BITS_DEF,
    parameter int ADDR_W   = xl_pkg::ADDR_W_DEF,
    parameter int DATA_W   = xl_pkg::DATA_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_all,
    input  logic              i_req,
    input  logic [VPN_W-1:0]  i_vpn,
    output logic              i_done,
    output logic              i_fault,
    output logic [PPN_W-1:0]  i_ppn,
    input  logic              d_req,
    input  logic [VPN_W-1:0]  d_vpn,
    output logic              d_done,
    output logic              d_fault,
    output logic [PPN_W-1:0]  d_ppn,
    input  logic [ADDR_W-1:0] table_base,
    output logic              mem_rd_req,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data
);
    import xl_pkg::*;

    logic             gnt_valid;
    xl_side_e         gnt_side;
    logic [VPN_W-1:0] gnt_vpn;
    logic             accept;
    logic [VPN_W-1:0] cur_vpn;
    logic             lk_hit;
    logic [PPN_W-1:0] lk_ppn;
    logic             wr_en;
    logic [PPN_W-1:0] wr_ppn;
    logic [PPN_W-1:0] rsp_ppn;
    logic             rsp_fault;

    xl_arb #(.VPN_W(VPN_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .i_req     (i_req),
        .i_vpn     (i_vpn),
        .d_req     (d_req),
        .d_vpn     (d_vpn),
        .accept    (accept),
        .gnt_valid (gnt_valid),
        .gnt_side  (gnt_side),
        .gnt_vpn   (gnt_vpn)
    );

    xl_array #(.VPN_W(VPN_W), .PPN_W(PPN_W), .SET_BITS(SET_BITS)) u_array (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush_all),
        .lk_vpn (cur_vpn),
        .lk_hit (lk_hit),
        .lk_ppn (lk_ppn),
        .wr_en  (wr_en),
        .wr_vpn (cur_vpn),
        .wr_ppn (wr_ppn)
    );

    xl_ctrl #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .gnt_valid    (gnt_valid),
        .gnt_side     (gnt_side),
        .gnt_vpn      (gnt_vpn),
        .accept       (accept),
        .cur_vpn      (cur_vpn),
        .lk_hit       (lk_hit),
        .lk_ppn       (lk_ppn),
        .wr_en        (wr_en),
        .wr_ppn       (wr_ppn),
        .table_base   (table_base),
        .mem_rd_req   (mem_rd_req),
        .mem_rd_addr  (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid),
        .mem_rd_data  (mem_rd_data),
        .i_done       (i_done),
        .d_done       (d_done),
        .rsp_ppn      (rsp_ppn),
        .rsp_fault    (rsp_fault)
    );

    assign i_ppn   = rsp_ppn;
    assign d_ppn   = rsp_ppn;
    assign i_fault = i_done & rsp_fault;
    assign d_fault = d_done & rsp_fault;

endmodule

// File: rtl/xl_chk.sv
module xl_chk #(
    parameter int PPN_W = xl_pkg::PPN_W_DEF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             i_done,
    input logic             d_done,
    input logic             i_fault,
    input logic             d_fault,
    input logic [PPN_W-1:0] i_ppn,
    input logic [PPN_W-1:0] d_ppn,
    input logic             mem_rd_req,
    input logic             mem_rd_valid,
    input logic             pte_ok,
    input logic [PPN_W-1:0] pte_ppn
);

    // R10
    done_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(i_done && d_done));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (i_done || d_done) |=> !(i_done || d_done));

    // R10
    fault_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((i_fault && !i_done) || (d_fault && !d_done)));

    // R3
    rd_strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_req |=> !mem_rd_req);

    // R5
    bad_entry_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !pte_ok) |=> (i_fault || d_fault));

    // R4
    good_entry_ppn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && pte_ok) |=>
            ((i_done && !i_fault && i_ppn == $past(pte_ppn)) ||
             (d_done && !d_fault && d_ppn == $past(pte_ppn))));

endmodule

bind l2_xlate_buf xl_chk #(.PPN_W(PPN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .i_done       (i_done),
    .d_done       (d_done),
    .i_fault      (i_fault),
    .d_fault      (d_fault),
    .i_ppn        (i_ppn),
    .d_ppn        (d_ppn),
    .mem_rd_req   (mem_rd_req),
    .mem_rd_valid (mem_rd_valid),
    .pte_ok       (mem_rd_data[0]),
    .pte_ppn      (mem_rd_data[DATA_W-1 -: PPN_W])
);

// File: tb/l2_xlate_buf_test.sv
`timescale 1ns/1ps
module l2_xlate_buf_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_main = 1'b0;
    logic        flush_mem = 1'b0;
    logic        flush_all;
    logic        i_req = 1'b0;
    logic [19:0] i_vpn = '0;
    logic        i_done, i_fault;
    logic [19:0] i_ppn;
    logic        d_req = 1'b0;
    logic [19:0] d_vpn = '0;
    logic        d_done, d_fault;
    logic [19:0] d_ppn;
    logic [31:0] table_base = 32'h0040_0000;
    logic        mem_rd_req;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;

    int          total = 0;
    int          bad = 0;
    int          rd_count = 0;
    logic [31:0] last_addr = '0;
    int          last_lat = 0;
    bit          flush_at_resp = 0;
    bit          flush_fired = 0;
    bit          finished = 0;

    // reference cache state
    bit          m_vld [32][2];
    logic [14:0] m_tag [32][2];
    bit          m_tog [32];

    assign flush_all = flush_main | flush_mem;

    always #2.5 clk = ~clk;

    l2_xlate_buf uut (
        .clk(clk), .rst_n(rst_n), .flush_all(flush_all),
        .i_req(i_req), .i_vpn(i_vpn), .i_done(i_done), .i_fault(i_fault), .i_ppn(i_ppn),
        .d_req(d_req), .d_vpn(d_vpn), .d_done(d_done), .d_fault(d_fault), .d_ppn(d_ppn),
        .table_base(table_base), .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
    );

    function automatic logic [31:0] pte_word(input logic [19:0] v);
        logic [19:0] p;
        p = (v ^ 20'h5A3C7) + 20'd13;
        return {p, 11'd0, ((v % 5) != 2)};
    endfunction

    function automatic bit m_hit(input logic [19:0] v);
        int idx;
        idx = int'(v[4:0]);
        return (m_vld[idx][0] && m_tag[idx][0] == v[19:5]) ||
               (m_vld[idx][1] && m_tag[idx][1] == v[19:5]);
    endfunction

    task automatic m_fill(input logic [19:0] v);
        int idx;
        int w;
        idx = int'(v[4:0]);
        if (!m_vld[idx][0]) w = 0;
        else if (!m_vld[idx][1]) w = 1;
        else begin
            w = int'(m_tog[idx]);
            m_tog[idx] = !m_tog[idx];
        end
        m_vld[idx][w] = 1;
        m_tag[idx][w] = v[19:5];
    endtask

    task automatic m_clear();
        for (int s = 0; s < 32; s++) begin
            m_vld[s][0] = 0;
            m_vld[s][1] = 0;
        end
    endtask

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    // page table memory
    initial begin
        forever begin
            @(negedge clk);
            if (mem_rd_req) begin
                int lat;
                logic [19:0] v;
                rd_count++;
                last_addr = mem_rd_addr;
                lat = 1 + int'($urandom % 3);
                last_lat = lat;
                v = 20'((mem_rd_addr - table_base) >> 2);
                repeat (lat) @(negedge clk);
                mem_rd_valid = 1'b1;
                mem_rd_data  = pte_word(v);
                if (flush_at_resp) begin
                    flush_mem   = 1'b1;
                    flush_fired = 1;
                end
                @(negedge clk);
                mem_rd_valid = 1'b0;
                flush_mem    = 1'b0;
            end
        end
    end

    task automatic xlate(input bit side, input logic [19:0] v, input string rq);
        int cnt;
        int rd0;
        bit got;
        bit stray;
        bit f;
        bit exp_hit;
        logic [19:0] p;
        logic [31:0] w;
        @(negedge clk);
        exp_hit = m_hit(v);
        rd0 = rd_count;
        flush_fired = 0;
        w = pte_word(v);
        if (side) begin d_req = 1'b1; d_vpn = v; end
        else begin i_req = 1'b1; i_vpn = v; end
        cnt = 0; got = 0; stray = 0; f = 0; p = '0;
        while (!got && cnt < 100) begin
            @(negedge clk);
            cnt++;
            if (side ? i_done : d_done) stray = 1;
            if (side ? d_done : i_done) begin
                got = 1;
                f = side ? d_fault : i_fault;
                p = side ? d_ppn : i_ppn;
            end
        end
        i_req = 1'b0;
        d_req = 1'b0;
        chk(got, "R2 done missing", 32'(cnt), 32'd0);
        chk(!stray, "R10 other side done", 32'(stray), 32'd0);
        if (!got) return;
        // hit or miss as the reference cache predicts
        chk((rd_count != rd0) == !exp_hit, rq, 32'(rd_count - rd0), exp_hit ? 32'd0 : 32'd1);
        if (exp_hit) begin
            chk(cnt == 2, "R2 hit latency", 32'(cnt), 32'd2);
            chk(!f && p == w[31:12], "R2 hit ppn", {11'd0, f, p}, {12'd0, w[31:12]});
        end else begin
            chk(rd_count == rd0 + 1, "R3 read count", 32'(rd_count - rd0), 32'd1);
            chk(last_addr == table_base + {10'd0, v, 2'b00}, "R3 read addr", last_addr,
                table_base + {10'd0, v, 2'b00});
            chk(cnt == 3 + last_lat, "R3 miss latency", 32'(cnt), 32'(3 + last_lat));
            if (w[0]) begin
                chk(!f && p == w[31:12], "R4 walk ppn", {11'd0, f, p}, {12'd0, w[31:12]});
                if (flush_fired) m_clear();
                else m_fill(v);
            end else begin
                chk(f, "R5 fault", 32'(f), 32'd1);
                if (flush_fired) m_clear();
            end
        end
    endtask

    task automatic both(input logic [19:0] vi, input logic [19:0] vd, input bit exp_data_first);
        int n;
        bit gi, gd, data_first;
        logic [19:0] pi, pd;
        bit fi, fd;
        @(negedge clk);
        i_req = 1'b1; i_vpn = vi;
        d_req = 1'b1; d_vpn = vd;
        gi = 0; gd = 0; data_first = 0; n = 0;
        pi = '0; pd = '0; fi = 0; fd = 0;
        while (!(gi && gd) && n < 200) begin
            @(negedge clk);
            n++;
            if (i_done && !gi) begin
                gi = 1; pi = i_ppn; fi = i_fault; i_req = 1'b0;
                if (!gd) data_first = 0;
            end
            if (d_done && !gd) begin
                gd = 1; pd = d_ppn; fd = d_fault; d_req = 1'b0;
                if (!gi) data_first = 1;
            end
        end
        i_req = 1'b0;
        d_req = 1'b0;
        chk(gi && gd, "R8 both served", {30'd0, gi, gd}, 32'd3);
        chk(data_first == exp_data_first, "R7 grant order", 32'(data_first), 32'(exp_data_first));
        chk(!fi && pi == pte_word(vi)[31:12], "R8 instr result", {11'd0, fi, pi}, {12'd0, pte_word(vi)[31:12]});
        chk(!fd && pd == pte_word(vd)[31:12], "R8 data result", {11'd0, fd, pd}, {12'd0, pte_word(vd)[31:12]});
        if (data_first) begin
            if (!m_hit(vd)) m_fill(vd);
            if (!m_hit(vi)) m_fill(vi);
        end else begin
            if (!m_hit(vi)) m_fill(vi);
            if (!m_hit(vd)) m_fill(vd);
        end
    endtask

    task automatic pulse_flush();
        @(negedge clk);
        flush_main = 1'b1;
        @(negedge clk);
        flush_main = 1'b0;
        m_clear();
    endtask

    initial begin
        void'($urandom(32'd7));
        m_clear();
        for (int s = 0; s < 32; s++) m_tog[s] = 0;
        repeat (4) @(negedge clk);
        chk(!i_done && !d_done && !mem_rd_req, "R11 in reset", {29'd0, i_done, d_done, mem_rd_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!i_done && !d_done && !mem_rd_req, "R11 after reset", {29'd0, i_done, d_done, mem_rd_req}, 32'd0);

        // arbitration: tie -> instruction, single instruction, tie -> data
        both(20'h00041, 20'h00062, 1'b0);
        xlate(1'b0, 20'h00024, "R8 single");
        both(20'h00045, 20'h00067, 1'b1);

        // replacement in set 9
        xlate(1'b0, 20'h00029, "R6 fill way0");
        xlate(1'b1, 20'h00049, "R6 fill way1");
        xlate(1'b0, 20'h00029, "R6 hit");
        xlate(1'b1, 20'h00049, "R6 hit");
        xlate(1'b0, 20'h00069, "R6 evict");
        xlate(1'b1, 20'h00049, "R6 survivor");
        xlate(1'b0, 20'h00029, "R6 refetch");
        xlate(1'b1, 20'h00069, "R6 kept");
        xlate(1'b0, 20'h00049, "R6 evicted");
        xlate(1'b1, 20'hA0009, "R1 high tag bits");
        xlate(1'b0, 20'hA0009, "R1 high tag hit");
        xlate(1'b1, 20'h0000A, "R1 neighbour set");

        // faulting entry is not cached
        xlate(1'b0, 20'h00089, "R5 first");
        xlate(1'b1, 20'h00089, "R5 walks again");

        // flush
        xlate(1'b0, 20'h00029, "R9 before");
        xlate(1'b0, 20'h00029, "R9 cached");
        pulse_flush();
        xlate(1'b0, 20'h00029, "R9 flushed");
        flush_at_resp = 1;
        xlate(1'b1, 20'h00049, "R9 collide");
        flush_at_resp = 0;
        xlate(1'b1, 20'h00049, "R9 not kept");

        // random traffic
        for (int k = 0; k < 300; k++) begin
            logic [19:0] v;
            if ($urandom % 30 == 0) pulse_flush();
            v = 20'((($urandom % 6) << 5) | ($urandom % 8));
            xlate(1'($urandom % 2), v, "R1 random");
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule